// File: doc/BRIEF.md
# Bit-Serial Variable-Precision Dot-Product Lane

This block is a multiply-accumulate lane with no multiplier. One operand of each product (the serial operand) arrives one bit per clock, most significant bit first. The other operand (the parallel operand) is presented whole on an 8-bit bus while its partner's bits stream in. Each accepted bit selects either zero or the parallel operand. The selected term is added into a per-product partial register that doubles each step. The finished product is then folded into a 24-bit accumulator. After the programmed number of pairs, the accumulator holds their dot product and a one-cycle completion flag is raised.

The serial precision can be set to any value from 1 to 8 bits. The cost of each product is exactly that many accepted bits, so halving the precision halves the run time. A sign setting chooses between unsigned arithmetic and two's-complement arithmetic. In signed mode both operands are signed, and the leading serial bit carries negative weight. Precision, sign setting and pair count are captured when a run is started. Feeding the lane is the job of the surrounding logic, which holds the parallel operand steady while that operand's bits are presented and raises a qualifier on each cycle that carries a bit.

Top module: `bsmac_lane`

## Requirements
- R1: After synchronous reset, `acc_out` is 0 and `done` is 0.
- R2: With `sign_mode`=0 at start, after a run `acc_out` equals the sum over all pairs of A*B (modulo 2^24). A is `par_op` as an unsigned 8-bit value. B is the unsigned P-bit value whose bits were given on `ser_bit`, most significant bit first.
- R3: With `sign_mode`=1 at start, A is taken as 8-bit two's complement and B as P-bit two's complement. The first serial bit of each pair therefore weighs -2^(P-1).
- R4: Every precision from 1 to 8 is honoured. A `prec_in` value of 0 acts as 1, and values above 8 act as 8. An `elem_cnt_in` value of 0 acts as 1.
- R5: `done` is high for exactly one cycle: the cycle after the clock edge that consumes the last serial bit of the last pair. With `ser_valid` held high, this is N*P+1 cycles after the start edge. `done` is never high before that cycle.
- R6: A cycle with `ser_valid`=0 consumes no bit and changes nothing. Serial bits offered while no run is active are ignored.
- R7: `start` clears the accumulator. After `done`, `acc_out` holds its value until the next `start` or `clear`.
- R8: `clear` zeroes `acc_out` on the next edge and ends any run without raising `done`. When `clear` and `start` are both high, `clear` wins.
- R9: Precision, sign setting and pair count are sampled only on `start`. Changing them during a run has no effect on the run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clear | input | 1 | Zero the accumulator and abort the run |
| start | input | 1 | Begin a run; captures configuration |
| prec_in | input | 4 | Serial operand precision in bits |
| sign_mode | input | 1 | 1 = two's-complement operands |
| elem_cnt_in | input | 8 | Number of pairs in the dot product |
| par_op | input | 8 | Parallel operand of the current pair |
| ser_bit | input | 1 | Current bit of the serial operand |
| ser_valid | input | 1 | `ser_bit` carries a bit this cycle |
| acc_out | output | 24 | Dot-product accumulator |
| done | output | 1 | One-cycle completion flag |

## Verification
The hardest cases to reach are those where the lane's captured state no longer matches its inputs. In one, the precision and sign pins are changed mid-run. In another, qualifier gaps fall in the middle of a product while the serial and parallel pins carry decoy values. The bench creates both cases from the driver. After start it scrambles the configuration pins, and it inserts idle cycles before bits with an inverted operand and a set serial bit. Out-of-range precision and a count of zero are also driven, to reach the clamping paths. A clear in the middle of a run, and a clear together with start, are each followed by live bits that must be ignored.

// File: rtl/bsmac_pkg.sv
package bsmac_pkg;
    localparam int A_W      = 8;
    localparam int MAX_PREC = 8;
    localparam int ACC_W    = 24;
    localparam int LEN_W    = 8;
    localparam int PREC_W   = $clog2(MAX_PREC + 1);
    localparam int PART_W   = 2 * A_W;

    typedef enum logic { TERM_ADD = 1'b0, TERM_SUB = 1'b1 } term_op_e;

    typedef struct packed {
        logic [PREC_W-1:0] prec;
        logic [LEN_W-1:0]  len;
        logic              sgn;
    } run_cfg_t;

    function automatic logic [PREC_W-1:0] fit_prec(input logic [PREC_W-1:0] p);
        if (p == '0)
            return PREC_W'(1);
        else if (p > PREC_W'(MAX_PREC))
            return PREC_W'(MAX_PREC);
        else
            return p;
    endfunction

    function automatic logic [LEN_W-1:0] fit_len(input logic [LEN_W-1:0] n);
        return (n == '0) ? LEN_W'(1) : n;
    endfunction

    function automatic logic [PART_W-1:0] widen_op(input logic [A_W-1:0] a, input logic sgn);
        if (sgn)
            return {{(PART_W-A_W){a[A_W-1]}}, a};
        else
            return {{(PART_W-A_W){1'b0}}, a};
    endfunction
endpackage

// File: rtl/bsmac_ctrl.sv
module bsmac_ctrl
    import bsmac_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              start,
    input  logic [PREC_W-1:0] prec_in,
    input  logic              sign_mode,
    input  logic [LEN_W-1:0]  elem_cnt_in,
    input  logic              ser_valid,
    output logic              step,
    output logic              lead_bit,
    output logic              prod_end,
    output logic              sgn,
    output logic              busy,
    output logic              done
);
    run_cfg_t          cfg_q;
    logic [PREC_W-1:0] bit_q;
    logic [LEN_W-1:0]  elem_q;
    logic              busy_q;
    logic              done_q;
    logic              last_bit;
    logic              last_elem;

    assign step      = busy_q && ser_valid;
    assign last_bit  = (bit_q == cfg_q.prec - PREC_W'(1));
    assign last_elem = (elem_q == cfg_q.len - LEN_W'(1));
    assign lead_bit  = (bit_q == '0);
    assign prod_end  = step && last_bit;
    assign sgn       = cfg_q.sgn;
    assign busy      = busy_q;
    assign done      = done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q  <= '{prec: PREC_W'(1), len: LEN_W'(1), sgn: 1'b0};
            bit_q  <= '0;
            elem_q <= '0;
            busy_q <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (clear) begin
                busy_q <= 1'b0;
                bit_q  <= '0;
                elem_q <= '0;
            end else if (start) begin
                cfg_q.prec <= fit_prec(prec_in);
                cfg_q.len  <= fit_len(elem_cnt_in);
                cfg_q.sgn  <= sign_mode;
                bit_q      <= '0;
                elem_q     <= '0;
                busy_q     <= 1'b1;
            end else if (step) begin
                if (last_bit) begin
                    bit_q <= '0;
                    if (last_elem) begin
                        busy_q <= 1'b0;
                        done_q <= 1'b1;
                    end else begin
                        elem_q <= elem_q + LEN_W'(1);
                    end
                end else begin
                    bit_q <= bit_q + PREC_W'(1);
                end
            end
        end
    end
endmodule

// File: rtl/bsmac_datapath.sv
module bsmac_datapath
    import bsmac_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             start,
    input  logic             step,
    input  logic             lead_bit,
    input  logic             prod_end,
    input  logic             sgn,
    input  logic [A_W-1:0]   par_op,
    input  logic             ser_bit,
    output logic [ACC_W-1:0] acc
);
    logic [PART_W-1:0] part_q;
    logic [PART_W-1:0] part_nx;
    logic [PART_W-1:0] term;
    logic [PART_W-1:0] doubled;
    logic [ACC_W-1:0]  part_wide;
    logic [ACC_W-1:0]  acc_q;
    term_op_e          op;

    always_comb begin
        term    = ser_bit ? widen_op(par_op, sgn) : '0;
        op      = (sgn && lead_bit) ? TERM_SUB : TERM_ADD;
        doubled = {part_q[PART_W-2:0], 1'b0};
        if (op == TERM_SUB)
            part_nx = doubled - term;
        else
            part_nx = doubled + term;
        if (sgn)
            part_wide = {{(ACC_W-PART_W){part_nx[PART_W-1]}}, part_nx};
        else
            part_wide = {{(ACC_W-PART_W){1'b0}}, part_nx};
    end

    always_ff @(posedge clk) begin
        if (rst || clear || start) begin
            part_q <= '0;
            acc_q  <= '0;
        end else if (step) begin
            if (prod_end) begin
                part_q <= '0;
                acc_q  <= acc_q + part_wide;
            end else begin
                part_q <= part_nx;
            end
        end
    end

    assign acc = acc_q;
endmodule

// File: rtl/bsmac_lane.sv
module bsmac_lane
    import bsmac_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              start,
    input  logic [PREC_W-1:0] prec_in,
    input  logic              sign_mode,
    input  logic [LEN_W-1:0]  elem_cnt_in,
    input  logic [A_W-1:0]    par_op,
    input  logic              ser_bit,
    input  logic              ser_valid,
    output logic [ACC_W-1:0]  acc_out,
    output logic              done
);
    logic step_w;
    logic lead_w;
    logic pend_w;
    logic sgn_w;
    logic busy_w;

    bsmac_ctrl u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .clear       (clear),
        .start       (start),
        .prec_in     (prec_in),
        .sign_mode   (sign_mode),
        .elem_cnt_in (elem_cnt_in),
        .ser_valid   (ser_valid),
        .step        (step_w),
        .lead_bit    (lead_w),
        .prod_end    (pend_w),
        .sgn         (sgn_w),
        .busy        (busy_w),
        .done        (done)
    );

    bsmac_datapath u_dp (
        .clk      (clk),
        .rst      (rst),
        .clear    (clear),
        .start    (start),
        .step     (step_w),
        .lead_bit (lead_w),
        .prod_end (pend_w),
        .sgn      (sgn_w),
        .par_op   (par_op),
        .ser_bit  (ser_bit),
        .acc      (acc_out)
    );
endmodule

// File: rtl/bsmac_lane_chk.sv
module bsmac_lane_chk
    import bsmac_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             clear,
    input logic             start,
    input logic             busy,
    input logic             done,
    input logic [ACC_W-1:0] acc
);
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R5

    AST_DONE_ENDS_RUN: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy); // R5

    AST_IDLE_NO_DONE: assert property (@(posedge clk) disable iff (rst)
        !busy |=> !done); // R6

    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (rst)
        clear |=> (acc == '0) && !busy); // R8

    AST_START_ZERO: assert property (@(posedge clk) disable iff (rst)
        (start && !clear) |=> (acc == '0) && busy); // R7

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start && !clear) |=> $stable(acc)); // R7
endmodule

bind bsmac_lane bsmac_lane_chk u_chk (
    .clk   (clk),
    .rst   (rst),
    .clear (clear),
    .start (start),
    .busy  (busy_w),
    .done  (done),
    .acc   (acc_out)
);

// File: tb/sim_bsmac_lane.sv
module sim_bsmac_lane;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        clear;
    logic        start;
    logic [3:0]  prec_in;
    logic        sign_mode;
    logic [7:0]  elem_cnt_in;
    logic [7:0]  par_op;
    logic        ser_bit;
    logic        ser_valid;
    logic [23:0] acc_out;
    logic        done;

    int checks = 0;
    int failures = 0;
    logic [23:0] exp_q[$];
    logic [7:0]  a_arr[8];
    logic [7:0]  b_arr[8];

    always #(CLK_PERIOD/2) clk = ~clk;

    bsmac_lane u0 (
        .clk(clk), .rst(rst), .clear(clear), .start(start),
        .prec_in(prec_in), .sign_mode(sign_mode), .elem_cnt_in(elem_cnt_in),
        .par_op(par_op), .ser_bit(ser_bit), .ser_valid(ser_valid),
        .acc_out(acc_out), .done(done)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // Monitor: pops an expected item for each done pulse (R2, R3)
    always @(negedge clk) begin
        if (!rst && done) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R2/R3 unexpected done", acc_out, -1);
            end else begin
                logic [23:0] e;
                e = exp_q.pop_front();
                check(acc_out == e, "R2/R3 dot product", acc_out, e);
            end
        end
    end

    function automatic int eff_prec(input int p);
        return (p == 0) ? 1 : ((p > 8) ? 8 : p);
    endfunction

    // Driver: runs one vector, pushes expectation, checks done timing
    task automatic run_vec(input int pcfg, input bit sgn, input int ncfg, input int gap);
        int p = eff_prec(pcfg);
        int n = (ncfg == 0) ? 1 : ncfg;
        longint sum = 0;
        int early = 0;
        logic [23:0] e;
        for (int i = 0; i < n; i++) begin
            longint av, bv;
            int bm = int'(b_arr[i]) & ((1 << p) - 1);
            av = (sgn && a_arr[i][7]) ? longint'(a_arr[i]) - 256 : longint'(a_arr[i]);
            bv = (sgn && ((bm >> (p - 1)) & 1) == 1) ? longint'(bm) - (longint'(1) << p) : longint'(bm);
            sum += av * bv;
        end
        e = 24'(sum);
        @(negedge clk);
        start = 1'b1; prec_in = 4'(pcfg); sign_mode = sgn; elem_cnt_in = 8'(ncfg);
        exp_q.push_back(e);
        @(negedge clk);
        start = 1'b0;
        prec_in = 4'(pcfg + 3);       // R9: scrambled after start
        sign_mode = ~sgn;
        elem_cnt_in = 8'(ncfg + 5);
        for (int i = 0; i < n; i++) begin
            for (int k = 0; k < p; k++) begin
                for (int g = 0; g < gap; g++) begin
                    ser_valid = 1'b0; ser_bit = 1'b1; par_op = ~a_arr[i];   // R6 decoys
                    @(negedge clk);
                    if (done) early++;
                end
                ser_valid = 1'b1; ser_bit = b_arr[i][p-1-k]; par_op = a_arr[i];
                @(negedge clk);
                if (done && !(i == n-1 && k == p-1)) early++;
            end
        end
        ser_valid = 1'b0; ser_bit = 1'b1;
        check(early == 0, "R5 no early done", early, 0);
        check(done == 1'b1, "R5 done after last bit", done, 1);
        @(negedge clk);
        check(done == 1'b0, "R5 done one cycle", done, 0);
        ser_valid = 1'b1;                 // R6: bits while idle ignored
        repeat (3) @(negedge clk);
        ser_valid = 1'b0;
        check(acc_out == e, "R7 hold after done", acc_out, e);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        check(1'b0, "watchdog", 0, 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst = 1'b1; clear = 1'b0; start = 1'b0; prec_in = 4'd8; sign_mode = 1'b0;
        elem_cnt_in = 8'd1; par_op = 8'd0; ser_bit = 1'b0; ser_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(acc_out == 24'd0, "R1 reset acc", acc_out, 0);
        check(done == 1'b0, "R1 reset done", done, 0);

        // R2: unsigned, full precision, three pairs
        a_arr[0] = 8'd255; b_arr[0] = 8'd255;
        a_arr[1] = 8'd17;  b_arr[1] = 8'd200;
        a_arr[2] = 8'd3;   b_arr[2] = 8'd1;
        run_vec(8, 1'b0, 3, 0);

        // R4: precision 1 unsigned, four pairs
        a_arr[0] = 8'd10; b_arr[0] = 8'd1;
        a_arr[1] = 8'd20; b_arr[1] = 8'd0;
        a_arr[2] = 8'd30; b_arr[2] = 8'd1;
        a_arr[3] = 8'd99; b_arr[3] = 8'd1;
        run_vec(1, 1'b0, 4, 0);

        // R3: signed precision 4 with negatives
        a_arr[0] = 8'hF9; b_arr[0] = 8'h09;   // -7 * -7
        a_arr[1] = 8'd100; b_arr[1] = 8'h08;  // 100 * -8
        a_arr[2] = 8'h80; b_arr[2] = 8'h07;   // -128 * 7
        run_vec(4, 1'b0 ^ 1'b1, 3, 0);

        // R3: signed corner -128 * -128, full precision
        a_arr[0] = 8'h80; b_arr[0] = 8'h80;
        a_arr[1] = 8'h7F; b_arr[1] = 8'hFF;
        run_vec(8, 1'b1, 2, 0);

        // R6: stalls with decoys, precision 5 unsigned
        a_arr[0] = 8'd77; b_arr[0] = 8'd31;
        a_arr[1] = 8'd5;  b_arr[1] = 8'd18;
        run_vec(5, 1'b0, 2, 2);

        // R4: precision 0 acts as 1, length 0 acts as 1
        a_arr[0] = 8'd123; b_arr[0] = 8'd1;
        run_vec(0, 1'b0, 0, 0);

        // R4: precision 12 acts as 8
        a_arr[0] = 8'd2;  b_arr[0] = 8'd250;
        a_arr[1] = 8'd40; b_arr[1] = 8'd129;
        run_vec(12, 1'b0, 2, 1);

        // R4: precision 2 signed
        a_arr[0] = 8'd50;  b_arr[0] = 8'd2;   // 50 * -2
        a_arr[1] = 8'hFE;  b_arr[1] = 8'd1;   // -2 * 1
        run_vec(2, 1'b1, 2, 0);

        // R8: clear mid-run aborts without done
        @(negedge clk);
        start = 1'b1; prec_in = 4'd8; sign_mode = 1'b0; elem_cnt_in = 8'd2;
        @(negedge clk);
        start = 1'b0; ser_valid = 1'b1; ser_bit = 1'b1; par_op = 8'd200;
        repeat (9) @(negedge clk);
        clear = 1'b1;
        @(negedge clk);
        clear = 1'b0;
        check(acc_out == 24'd0, "R8 clear zeroes acc", acc_out, 0);
        repeat (20) begin
            @(negedge clk);
            if (done) check(1'b0, "R8 no done after clear", done, 0);
        end
        check(acc_out == 24'd0, "R8 run aborted", acc_out, 0);

        // R8: clear and start together -> clear wins, lane stays idle
        clear = 1'b1; start = 1'b1; prec_in = 4'd1; elem_cnt_in = 8'd1;
        @(negedge clk);
        clear = 1'b0; start = 1'b0;
        repeat (5) @(negedge clk);
        ser_valid = 1'b0;
        check(acc_out == 24'd0, "R8 clear beats start", acc_out, 0);
        check(done == 1'b0, "R8 no done", done, 0);
        check(exp_q.size() == 0, "R2 all results seen", exp_q.size(), 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule